// File: doc/BRIEF.md
# ATA Taskfile Access Sequencer

This block turns a whole taskfile operation into the ordered run of single register accesses that a parallel ATA device expects. An upstream controller presents an operation code, a twelve-byte taskfile image, three qualifier flags and a control byte. It pulses `opValid` and waits for `opDone`. Downstream, the block drives a request/done handshake into a one-access PIO cycle engine. That engine performs the bus cycle and returns read data.

The operations are: load taskfile, read taskfile, issue command, select device, soft reset, interrupt enable and freeze. The block keeps the control byte it last wrote to the device. A load whose control byte is unchanged therefore skips the control write. A read of 48-bit addresses sets the high-order-byte flag, then puts back the plain control byte. The soft-reset pulse is held for a gap that is counted in clock cycles, derived from the clock frequency parameter. Each register read lands in a fixed byte of the result vector, which is valid when `opDone` pulses.

Register codes on `accAddr` are: 1 feature/error, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device, 7 status/command, 0xE device control. Taskfile and result byte k sits at bits [8k+7:8k]. Byte 0 is command (input) or status (result). Bytes 1 to 5 are feature/error, sector count, LBA low, LBA mid and LBA high. Byte 6 is device. Bytes 7 to 11 are the high-order copies of bytes 1 to 5. Operation codes are: 0 load, 1 read, 2 command, 3 select, 4 soft reset, 5 interrupt enable, 6 freeze, 7 no operation.

Top module: `tf_sequencer`

## Requirements
- R1: After reset `busy`, `accReq` and `opDone` are low and no control value is remembered, so the first load always writes the control register.
- R2: A load writes `ctlIn` to register 0xE first, and only if it differs from the remembered control value or none is remembered.
- R3: A load with `addrValid` and `lba48` writes taskfile bytes 7..11 to registers 1..5 in that order, then bytes 1..5 to registers 1..5 in that order.
- R4: A load with only `addrValid` writes bytes 1..5 to registers 1..5. Taskfile byte 6 goes to register 6 only when `devValid` is set, and always as the last access.
- R5: A read fetches registers 7, 1, 2, 3, 4, 5, 6 in that order into result bytes 0..6.
- R6: A read with `lba48` then writes `ctlIn | 0x80` to 0xE, reads registers 1..5 into result bytes 7..11, and finally writes plain `ctlIn` to 0xE.
- R7: A command operation writes taskfile byte 0 to register 7 as its only access.
- R8: Select writes 0xA0 (`devSel`=0) or 0xB0 (`devSel`=1) to register 6.
- R9: Soft reset writes `ctlIn`, `ctlIn | 0x04` and `ctlIn` to 0xE. After each of the first two writes completes, at least CLK_MHZ*GAP_US cycles pass before the next request.
- R10: Interrupt enable writes `ctlIn & ~0x02` to 0xE. Freeze writes `ctlIn | 0x02` to 0xE, then reads register 7 into result byte 0.
- R11: `accReq` stays high until `accDone`. `busy` is high through an operation, and `opDone` is a one-cycle pulse with `busy` low. `opValid` is ignored while busy.
- R12: Every completed write to 0xE, from any operation, becomes the remembered control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Start an operation (sampled when idle) |
| opCode | input | 3 | Operation code |
| tfIn | input | 96 | Taskfile image, twelve bytes |
| ctlIn | input | 8 | Device control byte for this operation |
| addrValid | input | 1 | Address registers are to be loaded |
| lba48 | input | 1 | 48-bit addressing, high-order bytes used |
| devValid | input | 1 | Device register is to be loaded |
| devSel | input | 1 | Device number for select |
| busy | output | 1 | Operation in progress |
| opDone | output | 1 | One-cycle end-of-operation pulse |
| result | output | 96 | Read results, twelve bytes |
| accReq | output | 1 | Access request to the cycle engine |
| accWrite | output | 1 | Access is a write |
| accAddr | output | 4 | Register code of the access |
| accWData | output | 8 | Write data |
| accRData | input | 8 | Read data from the cycle engine |
| accDone | input | 1 | Access finished |

## Verification
The hardest condition to reach is the skipped control write. It depends on history rather than on the current request: the remembered value may have been left by an interrupt enable, by the restore at the end of a 48-bit read, or by the last write of a soft reset. The stimulus chains these operations so that each is followed by a load carrying the very byte it left behind, and the scoreboard then expects no write to register 0xE. The soft-reset gap is measured from the completion of each pulse write to the next request. The cycle engine's latency is stretched for one operation so that the request is held for several cycles.

// File: rtl/tf_seq_pkg.sv
package tf_seq_pkg;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_READ   = 3'd1,
    OP_CMD    = 3'd2,
    OP_SELECT = 3'd3,
    OP_SRST   = 3'd4,
    OP_IRQON  = 3'd5,
    OP_FREEZE = 3'd6,
    OP_NOP    = 3'd7
  } opCode_t;

  localparam int TF_BYTES = 12;
  localparam int TF_W     = 8 * TF_BYTES;
  localparam int STEP_W   = 4;

  localparam logic [3:0] REG_DEV     = 4'h6;
  localparam logic [3:0] REG_STATCMD = 4'h7;
  localparam logic [3:0] REG_CTL     = 4'hE;

  localparam logic [7:0] CTL_NIEN = 8'h02;
  localparam logic [7:0] CTL_SRST = 8'h04;
  localparam logic [7:0] CTL_HOB  = 8'h80;
  localparam logic [7:0] DEVSEL0  = 8'hA0;
  localparam logic [7:0] DEVSEL1  = 8'hB0;

  // one register access as decoded for the current step
  typedef struct packed {
    logic       valid;
    logic       write;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [3:0] rdByte;
    logic       pause;
    logic       endOp;
  } access_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic complete;
  } strobe_t;

endpackage

// File: rtl/tf_seq_datapath.sv
module tf_seq_datapath
  import tf_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [STEP_W-1:0] step,
  input  logic [2:0]        opIn,
  input  logic [TF_W-1:0]   tfIn,
  input  logic [7:0]        ctlIn,
  input  logic              addrValidIn,
  input  logic              lba48In,
  input  logic              devValidIn,
  input  logic              devSelIn,
  input  logic [7:0]        accRData,
  output logic              stepValid,
  output logic              stepPause,
  output logic              stepEnd,
  output logic              accWrite,
  output logic [3:0]        accAddr,
  output logic [7:0]        accWData,
  output logic [TF_W-1:0]   result
);

  opCode_t          opReg;
  logic [TF_W-1:0]  tfReg;
  logic [7:0]       ctlReg;
  logic             addrV, wide, devV, devS;
  logic [7:0]       lastCtl;
  logic             lastValid;
  access_t          acc;

  function automatic logic [7:0] byteOf(input logic [TF_W-1:0] v, input logic [3:0] idx);
    return v[{idx, 3'b000} +: 8];
  endfunction

  // step decode: which access, if any, the current step performs
  always_comb begin
    acc = '0;
    case (opReg)
      OP_LOAD: begin
        acc.endOp = (step >= 4'd12);
        acc.write = 1'b1;
        if (step == 4'd0) begin
          acc.valid = !lastValid || (ctlReg != lastCtl);
          acc.addr  = REG_CTL;
          acc.wdata = ctlReg;
        end else if (step <= 4'd5) begin
          acc.valid = addrV && wide;
          acc.addr  = step;
          acc.wdata = byteOf(tfReg, step + 4'd6);
        end else if (step <= 4'd10) begin
          acc.valid = addrV;
          acc.addr  = step - 4'd5;
          acc.wdata = byteOf(tfReg, step - 4'd5);
        end else if (step == 4'd11) begin
          acc.valid = devV;
          acc.addr  = REG_DEV;
          acc.wdata = byteOf(tfReg, 4'd6);
        end
      end
      OP_READ: begin
        acc.endOp = (step >= 4'd14);
        if (step == 4'd0) begin
          acc.valid  = 1'b1;
          acc.addr   = REG_STATCMD;
        end else if (step <= 4'd5) begin
          acc.valid  = 1'b1;
          acc.addr   = step;
          acc.rdByte = step;
        end else if (step == 4'd6) begin
          acc.valid  = 1'b1;
          acc.addr   = REG_DEV;
          acc.rdByte = 4'd6;
        end else if (step == 4'd7) begin
          acc.valid  = wide;
          acc.write  = 1'b1;
          acc.addr   = REG_CTL;
          acc.wdata  = ctlReg | CTL_HOB;
        end else if (step <= 4'd12) begin
          acc.valid  = wide;
          acc.addr   = step - 4'd7;
          acc.rdByte = step - 4'd1;
        end else if (step == 4'd13) begin
          acc.valid  = wide;
          acc.write  = 1'b1;
          acc.addr   = REG_CTL;
          acc.wdata  = ctlReg;
        end
      end
      OP_CMD: begin
        acc.endOp = (step >= 4'd1);
        acc.valid = 1'b1;
        acc.write = 1'b1;
        acc.addr  = REG_STATCMD;
        acc.wdata = byteOf(tfReg, 4'd0);
      end
      OP_SELECT: begin
        acc.endOp = (step >= 4'd1);
        acc.valid = 1'b1;
        acc.write = 1'b1;
        acc.addr  = REG_DEV;
        acc.wdata = devS ? DEVSEL1 : DEVSEL0;
      end
      OP_SRST: begin
        acc.endOp = (step >= 4'd3);
        acc.valid = 1'b1;
        acc.write = 1'b1;
        acc.addr  = REG_CTL;
        acc.wdata = (step == 4'd1) ? (ctlReg | CTL_SRST) : ctlReg;
        acc.pause = (step != 4'd2);
      end
      OP_IRQON: begin
        acc.endOp = (step >= 4'd1);
        acc.valid = 1'b1;
        acc.write = 1'b1;
        acc.addr  = REG_CTL;
        acc.wdata = ctlReg & ~CTL_NIEN;
      end
      OP_FREEZE: begin
        acc.endOp = (step >= 4'd2);
        acc.valid = 1'b1;
        acc.write = (step == 4'd0);
        acc.addr  = (step == 4'd0) ? REG_CTL : REG_STATCMD;
        acc.wdata = ctlReg | CTL_NIEN;
      end
      default: acc.endOp = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opReg     <= OP_NOP;
      tfReg     <= '0;
      ctlReg    <= '0;
      addrV     <= 1'b0;
      wide      <= 1'b0;
      devV      <= 1'b0;
      devS      <= 1'b0;
      lastCtl   <= '0;
      lastValid <= 1'b0;
      result    <= '0;
    end else begin
      if (strobe.capture) begin
        opReg  <= opCode_t'(opIn);
        tfReg  <= tfIn;
        ctlReg <= ctlIn;
        addrV  <= addrValidIn;
        wide   <= lba48In;
        devV   <= devValidIn;
        devS   <= devSelIn;
        result <= '0;
      end
      if (strobe.complete) begin
        if (!acc.write)
          result[{acc.rdByte, 3'b000} +: 8] <= accRData;
        else if (acc.addr == REG_CTL) begin
          lastCtl   <= acc.wdata;
          lastValid <= 1'b1;
        end
      end
    end
  end

  assign stepValid = acc.valid;
  assign stepPause = acc.pause;
  assign stepEnd   = acc.endOp;
  assign accWrite  = acc.write;
  assign accAddr   = acc.addr;
  assign accWData  = acc.wdata;

  // R12: a finished control write is what the next load compares against
  assert_ctl_track_R12: assert property (@(posedge clk) disable iff (rst)
    (strobe.complete && acc.write && acc.addr == REG_CTL)
      |=> (lastValid && lastCtl == $past(acc.wdata)));

  // R11: capture and completion never coincide
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(strobe.capture && strobe.complete));

endmodule

// File: rtl/tf_seq_control.sv
module tf_seq_control
  import tf_seq_pkg::*;
#(
  parameter int unsigned GAP_CYC = 2000
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic              stepValid,
  input  logic              stepPause,
  input  logic              stepEnd,
  input  logic              accDone,
  output logic [STEP_W-1:0] step,
  output strobe_t           strobe,
  output logic              accReq,
  output logic              busy,
  output logic              opDone
);

  localparam int unsigned CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_GAP} state_t;

  state_t           state;
  logic [CNT_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      step   <= '0;
      gapCnt <= '0;
      opDone <= 1'b0;
    end else begin
      opDone <= 1'b0;
      case (state)
        S_IDLE: if (opValid) begin
          state <= S_RUN;
          step  <= '0;
        end
        S_RUN: begin
          if (stepEnd) begin
            opDone <= 1'b1;
            state  <= S_IDLE;
          end else if (!stepValid) begin
            step <= step + 1'b1;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: if (accDone) begin
          if (stepPause) begin
            gapCnt <= GAP_LOAD;
            state  <= S_GAP;
          end else begin
            step  <= step + 1'b1;
            state <= S_RUN;
          end
        end
        S_GAP: begin
          if (gapCnt == '0) begin
            step  <= step + 1'b1;
            state <= S_RUN;
          end else begin
            gapCnt <= gapCnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strobe.capture  = (state == S_IDLE) && opValid;
  assign strobe.complete = (state == S_WAIT) && accDone;
  assign accReq = (state == S_WAIT);
  assign busy   = (state != S_IDLE);

  // R11: a request is held until the engine finishes it
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (accReq && !accDone) |=> accReq);

  // R11: the end pulse lasts one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    opDone |=> !opDone);

  // R11: the end pulse comes with the block idle
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    opDone |-> !busy);

  // R9: a pause step is followed by a quiet bus, not an immediate request
  assert_gap_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (accReq && accDone && stepPause) |=> !accReq);

endmodule

// File: rtl/tf_sequencer.sv
module tf_sequencer
  import tf_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned GAP_US  = 20
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            opValid,
  input  logic [2:0]      opCode,
  input  logic [TF_W-1:0] tfIn,
  input  logic [7:0]      ctlIn,
  input  logic            addrValid,
  input  logic            lba48,
  input  logic            devValid,
  input  logic            devSel,
  output logic            busy,
  output logic            opDone,
  output logic [TF_W-1:0] result,
  output logic            accReq,
  output logic            accWrite,
  output logic [3:0]      accAddr,
  output logic [7:0]      accWData,
  input  logic [7:0]      accRData,
  input  logic            accDone
);

  localparam int unsigned GAP_CYC = CLK_MHZ * GAP_US;

  strobe_t           strobe;
  logic [STEP_W-1:0] step;
  logic              stepValid, stepPause, stepEnd;

  tf_seq_control #(.GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .opValid(opValid),
    .stepValid(stepValid), .stepPause(stepPause), .stepEnd(stepEnd),
    .accDone(accDone), .step(step), .strobe(strobe),
    .accReq(accReq), .busy(busy), .opDone(opDone)
  );

  tf_seq_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .step(step),
    .opIn(opCode), .tfIn(tfIn), .ctlIn(ctlIn),
    .addrValidIn(addrValid), .lba48In(lba48), .devValidIn(devValid), .devSelIn(devSel),
    .accRData(accRData), .stepValid(stepValid), .stepPause(stepPause), .stepEnd(stepEnd),
    .accWrite(accWrite), .accAddr(accAddr), .accWData(accWData), .result(result)
  );

endmodule

// File: tb/sim_tf_sequencer.sv
module sim_tf_sequencer;
  import tf_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SIM_MHZ    = 2;
  localparam int SIM_GAP_US = 20;
  localparam int GAP        = SIM_MHZ * SIM_GAP_US;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            opValid = 1'b0;
  logic [2:0]      opCode = 3'd7;
  logic [TF_W-1:0] tfIn = '0;
  logic [7:0]      ctlIn = 8'h00;
  logic            addrValid = 1'b0, lba48 = 1'b0, devValid = 1'b0, devSel = 1'b0;
  logic            busy, opDone, accReq, accWrite;
  logic [TF_W-1:0] result;
  logic [3:0]      accAddr;
  logic [7:0]      accWData;
  logic [7:0]      accRData;
  logic            accDone;

  always #(CLK_PERIOD/2) clk = ~clk;

  tf_sequencer #(.CLK_MHZ(SIM_MHZ), .GAP_US(SIM_GAP_US)) u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode), .tfIn(tfIn), .ctlIn(ctlIn),
    .addrValid(addrValid), .lba48(lba48), .devValid(devValid), .devSel(devSel),
    .busy(busy), .opDone(opDone), .result(result), .accReq(accReq), .accWrite(accWrite),
    .accAddr(accAddr), .accWData(accWData), .accRData(accRData), .accDone(accDone)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  int    cycle = 0;
  int    lat = 0;
  int    latLimit = 2;
  logic [12:0] expQ[$];
  int    reqStart[$];
  int    doneAt[$];
  logic [7:0] loRegs[16];
  logic [7:0] hiRegs[16];
  logic [7:0] ctlModel = 8'h00;
  logic [7:0] benchLast = 8'h00;
  logic       benchLastValid = 1'b0;
  logic [12:0] item;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [TF_W-1:0] act, input logic [TF_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TF_W-1:0] mkTf(input logic [7:0] b [12]);
    logic [TF_W-1:0] v = '0;
    for (int i = 0; i < 12; i++) v[8*i +: 8] = b[i];
    return v;
  endfunction

  task automatic pushW(input logic [3:0] a, input logic [7:0] d);
    expQ.push_back({1'b1, a, d});
  endtask
  task automatic pushR(input logic [3:0] a);
    expQ.push_back({1'b0, a, 8'h00});
  endtask
  task automatic noteCtl(input logic [7:0] d);
    pushW(REG_CTL, d);
    benchLast = d;
    benchLastValid = 1'b1;
  endtask

  // cycle engine model and scoreboard monitor
  initial begin
    accDone = 1'b0;
    accRData = 8'h00;
    for (int i = 0; i < 16; i++) begin
      loRegs[i] = 8'h10 + 8'(i);
      hiRegs[i] = 8'h60 + 8'(i);
    end
    forever begin
      @(negedge clk);
      cycle++;
      if (accDone) accDone = 1'b0;
      else if (accReq) begin
        if (lat == 0) reqStart.push_back(cycle);
        if (lat >= latLimit) begin
          lat = 0;
          doneAt.push_back(cycle);
          if (expQ.size() == 0)
            chk(1'b0, curReq, "unexpected access", {accWrite, accAddr, accWData}, '0);
          else begin
            item = expQ.pop_front();
            chk(item[12] == accWrite && item[11:8] == accAddr && (!accWrite || item[7:0] == accWData),
                curReq, "access order", {accWrite, accAddr, accWData}, item);
          end
          if (accWrite) begin
            if (accAddr == REG_CTL) ctlModel = accWData;
            else if (accAddr >= 4'd1 && accAddr <= 4'd5) begin
              hiRegs[accAddr] = loRegs[accAddr];
              loRegs[accAddr] = accWData;
            end else if (accAddr == REG_DEV) loRegs[6] = accWData;
          end else begin
            if (accAddr == REG_STATCMD) accRData = 8'h50;
            else if (ctlModel[7] && accAddr >= 4'd1 && accAddr <= 4'd5) accRData = hiRegs[accAddr];
            else accRData = loRegs[accAddr];
          end
          accDone = 1'b1;
        end else lat++;
      end
    end
  end

  task automatic runOp(input logic [2:0] code, input logic [TF_W-1:0] tf, input logic [7:0] ctl,
                       input logic av, input logic l48, input logic dv, input logic ds, input bit poke);
    int t = 0;
    @(negedge clk);
    opCode = code; tfIn = tf; ctlIn = ctl;
    addrValid = av; lba48 = l48; devValid = dv; devSel = ds;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      opCode = 3'd2; opValid = 1'b1;   // R11: start while busy must be ignored
      @(negedge clk);
      opValid = 1'b0;
    end
    while (!opDone && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) chk(1'b0, curReq, "watchdog", 0, 1);
    chk(busy == 1'b0, "R11", "idle with done", busy, 0);
    chk(expQ.size() == 0, curReq, "sequence complete", expQ.size(), 0);
    expQ.delete();
    @(negedge clk);
    chk(opDone == 1'b0, "R11", "done pulse width", opDone, 0);
  endtask

  task automatic expLoad(input logic [TF_W-1:0] tf, input logic [7:0] ctl,
                         input logic av, input logic l48, input logic dv);
    if (!benchLastValid || ctl != benchLast) noteCtl(ctl);
    if (av && l48) for (int i = 1; i <= 5; i++) pushW(4'(i), tf[8*(i+6) +: 8]);
    if (av) for (int i = 1; i <= 5; i++) pushW(4'(i), tf[8*i +: 8]);
    if (dv) pushW(REG_DEV, tf[48 +: 8]);
  endtask

  task automatic expRead(input logic [7:0] ctl, input logic l48);
    pushR(REG_STATCMD);
    for (int i = 1; i <= 5; i++) pushR(4'(i));
    pushR(REG_DEV);
    if (l48) begin
      noteCtl(ctl | 8'h80);
      for (int i = 1; i <= 5; i++) pushR(4'(i));
      noteCtl(ctl);
    end
  endtask

  function automatic logic [TF_W-1:0] readResult(input logic l48);
    logic [TF_W-1:0] v = '0;
    v[7:0] = 8'h50;
    for (int i = 1; i <= 6; i++) v[8*i +: 8] = loRegs[i];
    if (l48) for (int i = 1; i <= 5; i++) v[8*(i+6) +: 8] = hiRegs[i];
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b [12];
    logic [TF_W-1:0] tfA, tfB;
    b = '{8'hEC, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'hE0, 8'h91, 8'h92, 8'h93, 8'h94, 8'h95};
    tfA = mkTf(b);
    b = '{8'h24, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'h40, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5};
    tfB = mkTf(b);

    repeat (4) @(negedge clk);
    curReq = "R1";
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(accReq == 1'b0, "R1", "request in reset", accReq, 0);
    chk(opDone == 1'b0, "R1", "done in reset", opDone, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && accReq == 1'b0, "R1", "idle after reset", {busy, accReq}, 0);

    // R1/R4: first load writes control even for value 0x00, then low five and device
    curReq = "R4";
    expLoad(tfA, 8'h00, 1, 0, 1);
    runOp(3'd0, tfA, 8'h00, 1, 0, 1, 0, 0);

    // R2/R3: same control skipped, high-order bytes before low-order
    curReq = "R3";
    expLoad(tfB, 8'h00, 1, 1, 1);
    runOp(3'd0, tfB, 8'h00, 1, 1, 1, 0, 0);

    // R2: changed control byte, no other flags
    curReq = "R2";
    expLoad(tfA, 8'h08, 0, 0, 0);
    runOp(3'd0, tfA, 8'h08, 0, 0, 0, 0, 0);

    // R4: device flag only, long engine latency (R11 hold)
    curReq = "R4";
    latLimit = 5;
    expLoad(tfA, 8'h08, 0, 0, 1);
    runOp(3'd0, tfA, 8'h08, 0, 0, 1, 0, 0);
    latLimit = 2;

    // R5: plain read
    curReq = "R5";
    expRead(8'h08, 0);
    runOp(3'd1, tfA, 8'h08, 0, 0, 0, 0, 0);
    chk(result == readResult(0), "R5", "read result", result, readResult(0));

    // R6: 48-bit read
    curReq = "R6";
    expRead(8'h08, 1);
    runOp(3'd1, tfA, 8'h08, 0, 1, 0, 0, 0);
    chk(result == readResult(1), "R6", "hob read result", result, readResult(1));
    chk(ctlModel == 8'h08, "R6", "control restored", ctlModel, 8'h08);

    // R12: restored value is remembered, load with 0x08 makes no access
    curReq = "R12";
    expLoad(tfA, 8'h08, 0, 0, 0);
    runOp(3'd0, tfA, 8'h08, 0, 0, 0, 0, 0);

    // R7: command
    curReq = "R7";
    pushW(REG_STATCMD, 8'hEC);
    runOp(3'd2, tfA, 8'h08, 0, 0, 0, 0, 0);

    // R8: select both devices
    curReq = "R8";
    pushW(REG_DEV, 8'hA0);
    runOp(3'd3, tfA, 8'h08, 0, 0, 0, 0, 0);
    pushW(REG_DEV, 8'hB0);
    runOp(3'd3, tfA, 8'h08, 0, 0, 0, 1, 0);

    // R9/R11: soft reset with gaps, start pulse while busy ignored
    curReq = "R9";
    reqStart.delete(); doneAt.delete();
    noteCtl(8'h0A); pushW(REG_CTL, 8'h0E); noteCtl(8'h0A);
    runOp(3'd4, tfA, 8'h0A, 0, 0, 0, 0, 1);
    if (reqStart.size() >= 3 && doneAt.size() >= 2) begin
      chk(reqStart[1] - doneAt[0] >= GAP, "R9", "gap after first write", reqStart[1] - doneAt[0], GAP);
      chk(reqStart[2] - doneAt[1] >= GAP, "R9", "gap after pulse write", reqStart[2] - doneAt[1], GAP);
    end else chk(1'b0, "R9", "access count", reqStart.size(), 3);

    // R10: interrupt enable clears bit 1; R12 then skips the control write
    curReq = "R10";
    noteCtl(8'h08);
    runOp(3'd5, tfA, 8'h0A, 0, 0, 0, 0, 0);
    curReq = "R12";
    expLoad(tfA, 8'h08, 0, 0, 0);
    runOp(3'd0, tfA, 8'h08, 0, 0, 0, 0, 0);

    // R10: freeze sets bit 1, then status read
    curReq = "R10";
    noteCtl(8'h0A); pushR(REG_STATCMD);
    runOp(3'd6, tfA, 8'h08, 0, 0, 0, 0, 0);
    chk(result == TF_W'(8'h50), "R10", "freeze status", result, TF_W'(8'h50));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule